// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Read Rewind

This block is a single-clock FIFO controller built around an inferred two-port memory. The data path is 18 bits wide and the depth is a power of two set by a parameter. A strap input is captured during master reset and selects one of two read styles. In standard style a word reaches the registered output only after a read request is accepted. In fall-through style the oldest stored word moves onto the output by itself, and a read request consumes it.

Two status outputs keep the same pins in both styles, but their meaning changes. In standard style they report full and empty, both active low. In fall-through style they report input-ready and output-ready, both active low. There are two reset inputs. Master reset clears the whole block and latches the read style. Partial reset clears the pointers and the output but keeps the style already latched. A rewind request moves only the read position back to memory location zero, so data written since the last reset can be read again. The write position is not changed.

Top module: `dualmode_fifo`

## Requirements
- R1: While `mrst` is high at a clock edge, the block latches `mode_strap` as the read style (0 = standard, 1 = fall-through) and clears both positions and `rd_data` to zero. `mode_strap` has no effect at any other edge.
- R2: While `prst` is high at a clock edge (and `mrst` is low), the block clears both positions and `rd_data` to zero and keeps the latched read style.
- R3: In standard style, a read accepted at an edge places the oldest stored word on `rd_data` after that edge, and `rd_data` then holds until the next accepted read. Words leave in write order.
- R4: In standard style, `full_ir` is 0 exactly when DEPTH words are stored, and `empty_or` is 0 exactly when no word is stored or a rewind is in progress.
- R5: In fall-through style, a word written into an empty FIFO at edge t is on `rd_data` after edge t+1 without a read request. A read while a word is presented consumes it and brings up the next stored word at the same edge.
- R6: In fall-through style, `full_ir` is 0 while fewer than DEPTH words are held in memory, so the block holds DEPTH+1 words counting the presented one. `empty_or` is 0 exactly when a valid word is on `rd_data`.
- R7: A write while DEPTH words are held in memory is dropped. It changes neither the contents nor the flags.
- R8: A read when no word is available is ignored. In standard style `rd_data` holds its value. In fall-through style the output stays not-ready.
- R9: `rt_req` high at an edge sets the read position to location 0, leaves the write position unchanged, and makes the block ignore reads at that edge and at the next two edges. Later reads start again from the first word written since reset.
- R10: For the two cycles that follow an edge with `rt_req` high, `empty_or` is forced to 0 in standard style and to 1 in fall-through style. After that the flags come from the restored positions, and in fall-through style location 0 is presented one edge later.
- R11: Occupancy is the difference of two read/write positions that each carry one bit more than the address. A FIFO that has just become full and one that has just been emptied (same address on both sides) report opposite flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both reading and writing |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| mode_strap | input | 1 | Read-style select, sampled only during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Word to write |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Rewind request for the read side |
| rd_data | output | 18 | Registered output word |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through), active low |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through), active low |

## Verification
A wrong position or occupancy shows up at the ports within one edge, as a flag that disagrees with the words written and read. It can also stay hidden until the affected word is read out, when the wrong word appears on `rd_data`. For this reason the bench compares data and both flags against a behavioural queue model after every edge. A rewind fault shows up two or three edges after the request, when the forced flag is released and the first word should appear again. A style latched at the wrong time shows up one edge after the first write, because only fall-through style presents that word without a read request.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dmf_ram.sv
module dmf_ram #(
  parameter int unsigned WIDTH = 18,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register with synchronous clear, mapped onto the RAM output stage.
  always_ff @(posedge clk) begin
    if (clr)     q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dmf_ptr_ctl.sv
module dmf_ptr_ctl #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned RT_CYC = 2,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1,
  localparam int unsigned CW    = $clog2(RT_CYC + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          rd_take,
  input  logic          rt_req,
  output logic          wr_go,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] cnt,
  output logic [PW-1:0] cnt_nxt,
  output logic          busy,
  output logic          busy_nxt
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0] wptr, rptr, wptr_n, rptr_n;
  logic [CW-1:0] rtc, rtc_n;

  assign cnt   = wptr - rptr;
  assign busy  = (rtc != '0);
  assign wr_go = wr_en && (cnt != FULL_CNT) && !clr;
  assign waddr = wptr[AW-1:0];
  assign raddr = rptr[AW-1:0];

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    rtc_n  = rtc;
    if (clr) begin
      wptr_n = '0;
      rptr_n = '0;
      rtc_n  = '0;
    end else begin
      if (wr_go) wptr_n = wptr + PW'(1);
      if (rt_req) begin
        rptr_n = '0;
        rtc_n  = CW'(RT_CYC);
      end else begin
        if (rd_take) rptr_n = rptr + PW'(1);
        if (rtc != '0) rtc_n = rtc - CW'(1);
      end
    end
  end

  assign cnt_nxt  = wptr_n - rptr_n;
  assign busy_nxt = (rtc_n != '0);

  always_ff @(posedge clk) begin
    wptr <= wptr_n;
    rptr <= rptr_n;
    rtc  <= rtc_n;
  end

  // R11: occupancy never exceeds the memory size
  a_r11_cnt_bounded: assert property (@(posedge clk) disable iff (clr)
    cnt <= FULL_CNT);
  // R7: write while full leaves the write side alone
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (clr)
    (wr_en && cnt == FULL_CNT) |=> $stable(wptr));
  // R8: nothing stored, no read advance
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (clr)
    (cnt == '0 && !rt_req) |=> $stable(rptr));
  // R9: rewind lands on location zero
  a_r9_rewind_zero: assert property (@(posedge clk) disable iff (clr)
    rt_req |=> (rptr == '0));
  // R9: rewind leaves the write side untouched
  a_r9_write_kept: assert property (@(posedge clk) disable iff (clr)
    (rt_req && !wr_en) |=> $stable(wptr));
endmodule

// File: rtl/dmf_out_ctl.sv
module dmf_out_ctl
  import dmf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          strap,
  input  logic          rd_en,
  input  logic          rt_req,
  input  logic [PW-1:0] cnt,
  input  logic [PW-1:0] cnt_nxt,
  input  logic          busy,
  input  logic          busy_nxt,
  output logic          rd_take,
  output rd_mode_e      mode,
  output logic          full_ir,
  output logic          empty_or
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic     clr, has_words, take_std, take_ff;
  logic     ov, ov_n, full_n, fi_n, eo_n;
  rd_mode_e mode_n;

  assign clr       = mrst || prst;
  assign mode_n    = mrst ? rd_mode_e'(strap) : mode;
  assign has_words = (cnt != '0);
  assign take_std  = rd_en && has_words && !busy && !rt_req;
  assign take_ff   = has_words && !busy && !rt_req && (!ov || rd_en);
  assign rd_take   = !clr && ((mode == RD_FWFT) ? take_ff : take_std);

  always_comb begin
    if (clr || mode != RD_FWFT) ov_n = 1'b0;
    else if (rt_req)            ov_n = 1'b0;
    else if (take_ff)           ov_n = 1'b1;
    else if (rd_en)             ov_n = 1'b0;
    else                        ov_n = ov;
  end

  assign full_n = (cnt_nxt == FULL_CNT);

  always_comb begin
    if (mode_n == RD_FWFT) begin
      fi_n = full_n;
      eo_n = busy_nxt ? 1'b1 : !ov_n;
    end else begin
      fi_n = !full_n;
      eo_n = busy_nxt ? 1'b0 : (cnt_nxt != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) mode <= rd_mode_e'(strap);
    ov       <= ov_n;
    full_ir  <= fi_n;
    empty_or <= eo_n;
  end

  // R10: standard style reports empty through a rewind
  a_r10_std_forced: assert property (@(posedge clk) disable iff (clr)
    (mode == RD_STD && busy) |-> !empty_or);
  // R10: fall-through style reports not-ready through a rewind
  a_r10_ff_forced: assert property (@(posedge clk) disable iff (clr)
    (mode == RD_FWFT && busy) |-> empty_or);
  // R5: a presented word stays until consumed or rewound
  a_r5_head_held: assert property (@(posedge clk) disable iff (clr)
    (mode == RD_FWFT && ov && !rd_en && !rt_req) |=> ov);
endmodule

// File: rtl/dualmode_fifo.sv
module dualmode_fifo
  import dmf_pkg::*;
#(
  parameter int unsigned WIDTH     = 18,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned RT_CYCLES = 2,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned PW       = AW + 1
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic             mode_strap,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rt_req,
  output logic [WIDTH-1:0] rd_data,
  output logic             full_ir,
  output logic             empty_or
);
  logic          clr, wr_go, rd_take, busy, busy_nxt;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] cnt, cnt_nxt;
  rd_mode_e      mode;

  assign clr = mrst || prst;

  dmf_ptr_ctl #(.DEPTH(DEPTH), .RT_CYC(RT_CYCLES)) u_ptr (
    .clk(clk), .clr(clr), .wr_en(wr_en), .rd_take(rd_take), .rt_req(rt_req),
    .wr_go(wr_go), .waddr(waddr), .raddr(raddr), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .busy(busy), .busy_nxt(busy_nxt)
  );

  dmf_out_ctl #(.DEPTH(DEPTH)) u_out (
    .clk(clk), .mrst(mrst), .prst(prst), .strap(mode_strap), .rd_en(rd_en),
    .rt_req(rt_req), .cnt(cnt), .cnt_nxt(cnt_nxt), .busy(busy),
    .busy_nxt(busy_nxt), .rd_take(rd_take), .mode(mode), .full_ir(full_ir),
    .empty_or(empty_or)
  );

  dmf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .clr(clr), .we(wr_go), .waddr(waddr), .wdata(wr_data),
    .re(rd_take), .raddr(raddr), .q(rd_data)
  );

  // R1: the read style changes only under master reset
  a_r1_mode_sticky: assert property (@(posedge clk) disable iff (mrst)
    !mrst |=> $stable(mode));
  // R8: standard style output holds while nothing can be read
  a_r8_std_empty_hold: assert property (@(posedge clk) disable iff (clr)
    (mode == RD_STD && !empty_or) |=> $stable(rd_data));
endmodule

// File: tb/dualmode_fifo_test.sv
`timescale 1ns/1ps
module dualmode_fifo_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        mrst = 1'b1, prst = 1'b0, mode_strap = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, rt_req = 1'b0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic        full_ir, empty_or;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dualmode_fifo uut (
    .clk(clk), .mrst(mrst), .prst(prst), .mode_strap(mode_strap),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rt_req(rt_req),
    .rd_data(rd_data), .full_ir(full_ir), .empty_or(empty_or)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: history of words written since reset and a read index
  logic [17:0] hist[$];
  int          ridx = 0, m_rtc = 0;
  bit          m_ov = 0, m_mode = 0, mvalid = 0;
  logic [17:0] m_q = '0;

  task automatic m_clear();
    hist.delete();
    ridx = 0; m_rtc = 0; m_ov = 0; m_q = '0;
  endtask

  always @(posedge clk) begin : model
    int  cnt;
    bit  busy, take, wok;
    if (mrst) begin
      m_mode = mode_strap; m_clear(); mvalid = 1;
    end else if (prst) begin
      m_clear();
    end else if (mvalid) begin
      cnt  = hist.size() - ridx;
      busy = (m_rtc != 0);
      wok  = wr_en && (cnt < DEPTH);
      if (!m_mode) take = rd_en && cnt > 0 && !busy && !rt_req;
      else         take = cnt > 0 && !busy && !rt_req && (!m_ov || rd_en);
      if (m_mode) begin
        if (rt_req)     m_ov = 0;
        else if (take)  m_ov = 1;
        else if (rd_en) m_ov = 0;
      end
      if (take) begin m_q = hist[ridx]; ridx++; end
      if (wok) hist.push_back(wr_data);
      if (rt_req) begin ridx = 0; m_rtc = 2; end
      else if (m_rtc > 0) m_rtc--;
    end
  end

  always @(negedge clk) begin : compare
    int cnt2;
    bit efi, eeo;
    if (mvalid && !done) begin
      cnt2 = hist.size() - ridx;
      if (!m_mode) begin
        efi = (cnt2 != DEPTH);
        eeo = (m_rtc != 0) ? 1'b0 : (cnt2 != 0);
      end else begin
        efi = (cnt2 == DEPTH);
        eeo = (m_rtc != 0) ? 1'b1 : !m_ov;
      end
      chk(m_mode ? "R5 data" : "R3 data", 32'(rd_data), 32'(m_q));
      chk(m_mode ? "R6 full_ir" : "R4 full_ir", 32'(full_ir), 32'(efi));
      chk((m_rtc != 0) ? "R10 empty_or" : (m_mode ? "R6 empty_or" : "R4 empty_or"),
          32'(empty_or), 32'(eeo));
    end
  end

  task automatic cyc(input bit w, input logic [17:0] d, input bit r, input bit t);
    wr_en = w; wr_data = d; rd_en = r; rt_req = t;
    @(negedge clk);
    wr_en = 0; rd_en = 0; rt_req = 0;
  endtask

  task automatic do_reset(input bit master, input bit strap);
    mrst = master; prst = !master; mode_strap = strap;
    @(negedge clk); @(negedge clk);
    mrst = 0; prst = 0; mode_strap = !strap;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 50000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<50000", n_cyc);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    // ---- standard style
    do_reset(1, 0);
    chk("R1 reset data", 32'(rd_data), 0);
    chk("R1 reset full_ir", 32'(full_ir), 1);
    chk("R1 reset empty_or", 32'(empty_or), 0);
    for (int i = 0; i < 3; i++) cyc(1, 18'h100 + 18'(i), 0, 0);
    cyc(0, 0, 1, 0);
    chk("R3 first read", 32'(rd_data), 32'h100);
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R8 empty read holds", 32'(rd_data), 32'h102);
    chk("R8 empty flag", 32'(empty_or), 0);
    for (int i = 0; i < DEPTH + 4; i++) cyc(1, 18'h200 + 18'(i), 0, 0);
    chk("R7 full flag", 32'(full_ir), 0);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, 0);
    chk("R11 last of fill", 32'(rd_data), 32'h200 + DEPTH - 1);
    chk("R11 empty after equal address", 32'(empty_or), 0);
    chk("R11 not full", 32'(full_ir), 1);
    // ---- partial reset keeps standard style
    do_reset(0, 1);
    chk("R2 data cleared", 32'(rd_data), 0);
    chk("R2 style kept empty", 32'(empty_or), 0);
    cyc(1, 18'h300, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R1 strap ignored no fall-through", 32'(rd_data), 0);
    for (int i = 1; i < 5; i++) cyc(1, 18'h300 + 18'(i), 0, 0);
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    chk("R3 second read", 32'(rd_data), 32'h301);
    cyc(0, 0, 1, 1);
    chk("R10 std forced empty", 32'(empty_or), 0);
    chk("R9 read at rewind ignored", 32'(rd_data), 32'h301);
    cyc(0, 0, 1, 0);
    chk("R10 std forced empty 2", 32'(empty_or), 0);
    cyc(0, 0, 1, 0);
    chk("R9 read during rewind ignored", 32'(rd_data), 32'h301);
    chk("R10 flags re-evaluated", 32'(empty_or), 1);
    cyc(0, 0, 1, 0);
    chk("R9 rewound to first word", 32'(rd_data), 32'h300);
    // ---- fall-through style
    do_reset(1, 1);
    chk("R1 ff reset ready", 32'(full_ir), 0);
    chk("R1 ff reset not valid", 32'(empty_or), 1);
    cyc(1, 18'h400, 0, 0);
    chk("R5 not yet presented", 32'(empty_or), 1);
    cyc(0, 0, 0, 0);
    chk("R5 presented", 32'(rd_data), 32'h400);
    chk("R5 valid", 32'(empty_or), 0);
    cyc(0, 0, 1, 0);
    chk("R5 consumed", 32'(empty_or), 1);
    cyc(0, 0, 1, 0);
    chk("R8 ff empty read", 32'(empty_or), 1);
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, 18'h500 + 18'(i), 0, 0);
    chk("R6 full at depth+1", 32'(full_ir), 1);
    chk("R6 head word", 32'(rd_data), 32'h500);
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 1, 0);
    chk("R7 extra words dropped", 32'(empty_or), 1);
    chk("R6 last word", 32'(rd_data), 32'h500 + DEPTH);
    do_reset(0, 0);
    chk("R2 ff style kept", 32'(empty_or), 1);
    chk("R2 ff ready", 32'(full_ir), 0);
    for (int i = 0; i < 3; i++) cyc(1, 18'h600 + 18'(i), 0, 0);
    cyc(0, 0, 0, 0); cyc(0, 0, 1, 0);
    chk("R5 next word", 32'(rd_data), 32'h601);
    cyc(0, 0, 0, 1);
    chk("R10 ff forced", 32'(empty_or), 1);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R10 ff not yet", 32'(empty_or), 1);
    cyc(0, 0, 0, 0);
    chk("R10 word zero presented", 32'(rd_data), 32'h600);
    chk("R9 ready again", 32'(empty_or), 0);
    // ---- random traffic in both styles
    for (int m = 0; m < 2; m++) begin
      do_reset(1, m[0]);
      for (int i = 0; i < 600; i++) begin
        if (i % 150 == 149) do_reset(0, 0);
        else cyc($urandom_range(0, 99) < 55, 18'($urandom),
                 $urandom_range(0, 99) < 45, 0);
      end
    end
    finish_run();
  end
endmodule